// File: doc/BRIEF.md
# Gray-Coded Counter Clock Crossing

This block moves a running counter value from one clock domain into another clock domain with no fixed phase or frequency relation to the first. The source side keeps a binary count that advances by one whenever a step input is high at a source clock edge, wrapping from its all-ones value back to zero. The same edge registers the Gray-coded form of the new count. Each Gray bit is carried into the destination domain by its own chain of destination-clock flops. The destination side converts the synchronized Gray word back to binary in a final register.

Consecutive Gray values differ in exactly one bit. A sample that catches some bits before a change and others after it therefore still equals either the old count or the new one. The destination count only ever moves forward, and it may skip values when the destination clock is the slower of the two.

There is no valid/ready interface. The crossing is level-sampled: the source never waits and the destination cannot push back. Back-pressure is neither needed nor possible, because the destination always reads the latest count it has captured.

Top module: `gray_count_xing`

## Requirements
- R1: While `src_rst_n` is low, `src_count` and `src_gray` are zero. While `dst_rst_n` is low, `dst_count` is zero.
- R2: After every source edge, `src_gray` equals `src_count ^ (src_count >> 1)`, with bit 0 as the least significant bit.
- R3: At each source edge where `src_step` is 1, `src_count` increases by one, going from 2^WIDTH-1 to 0. Where `src_step` is 0, `src_count` holds.
- R4: Two successive values of `src_gray`, one source cycle apart, differ in at most one bit position.
- R5: The Gray word that enters the synchronizers is driven by a source flop. It does not change between the falling edge of `src_clk` and the next rising edge.
- R6: Each Gray bit passes through SYNC_STAGES destination flops, with SYNC_STAGES of at least 2. Once the source stops stepping, `dst_count` equals `src_count` within SYNC_STAGES+2 destination cycles.
- R7: Between two destination cycles, `dst_count` moves forward modulo 2^WIDTH by no more than the number of source steps that fit in one crossing latency. It never moves backward.
- R8: Every `dst_count` value is a count the source held recently. It trails `src_count` by at most the number of source steps that fit in one crossing latency.
- R9: `dst_count` is the binary decode of the synchronized Gray word from the previous destination edge. Bit i is the XOR of Gray bits WIDTH-1 down to i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Source domain clock |
| src_rst_n | input | 1 | Source domain asynchronous reset, active low |
| src_step | input | 1 | Advance the count by one at this source edge |
| src_count | output | WIDTH | Binary count in the source domain |
| src_gray | output | WIDTH | Registered Gray form of the count (launch word) |
| dst_clk | input | 1 | Destination domain clock |
| dst_rst_n | input | 1 | Destination domain asynchronous reset, active low |
| dst_count | output | WIDTH | Decoded binary count in the destination domain |

## Verification
Two events can fall in the same cycle: the source wrapping from all-ones to zero, and a destination edge that captures the Gray word while it is changing. The bench provokes this by driving the count directly to its maximum and then stepping once. It does so both with a slower destination clock and with a faster one, and it also runs long stretches of random stepping. At every destination sample the bench computes the forward distance from the previous decoded value and the lag behind the source count. Any backward move, or any value the source never held, shows up as a distance beyond the latency bound.

// File: rtl/gxc_pkg.sv
package gxc_pkg;
  localparam int unsigned GXC_MIN_STAGES = 2;
  localparam int unsigned GXC_MIN_WIDTH  = 2;
endpackage

// File: rtl/gxc_src_count.sv
module gxc_src_count #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [WIDTH-1:0] count_o,
  output logic [WIDTH-1:0] gray_o
);
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_nx;
  logic [WIDTH-1:0] gray_q;

  assign count_nx = count_q + WIDTH'(step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      gray_q  <= '0;
    end else begin
      count_q <= count_nx;
      gray_q  <= count_nx ^ (count_nx >> 1);
    end
  end

  assign count_o = count_q;
  assign gray_o  = gray_q;

  // R1: reset holds the source state at zero
  a_r1_src_reset: assert property (@(posedge clk)
    !rst_n |-> (count_q == '0 && gray_q == '0));

  // R3: step-by-one with wrap
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> count_q == WIDTH'($past(count_q) + WIDTH'($past(step))));

  // R4: launch word changes in at most one bit
  a_r4_one_bit_change: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/gxc_sync_bit.sv
module gxc_sync_bit #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d};
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/gxc_gray_dec.sv
module gxc_gray_dec #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] gray_i,
  output logic [WIDTH-1:0] bin_o
);
  localparam logic [WIDTH-1:0] HALF = WIDTH'(1) << (WIDTH - 1);

  logic [WIDTH-1:0] bin_d;
  logic [WIDTH-1:0] bin_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_dec
    assign bin_d[i] = ^(gray_i >> i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bin_q <= '0;
    else        bin_q <= bin_d;
  end

  assign bin_o = bin_q;

  // R1: destination reset
  a_r1_dst_reset: assert property (@(posedge clk) !rst_n |-> bin_q == '0);

  // R9: re-encoding the output gives back the sampled Gray word
  a_r9_decode_match: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (bin_q ^ (bin_q >> 1)) == $past(gray_i));

  // R7: never a backward move (forward distance below half the range)
  a_r7_no_backward: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> WIDTH'(bin_q - $past(bin_q)) < HALF);
endmodule

// File: rtl/gray_count_xing.sv
module gray_count_xing #(
  parameter int unsigned WIDTH       = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             src_clk,
  input  logic             src_rst_n,
  input  logic             src_step,
  output logic [WIDTH-1:0] src_count,
  output logic [WIDTH-1:0] src_gray,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic [WIDTH-1:0] dst_count
);
  import gxc_pkg::*;

  logic [WIDTH-1:0] launch_w;
  logic [WIDTH-1:0] synced_w;

  gxc_src_count #(.WIDTH(WIDTH)) i_src (
    .clk(src_clk), .rst_n(src_rst_n), .step(src_step),
    .count_o(src_count), .gray_o(launch_w)
  );

  assign src_gray = launch_w;

  for (genvar b = 0; b < WIDTH; b++) begin : g_sync
    gxc_sync_bit #(.STAGES(SYNC_STAGES)) i_bit (
      .clk(dst_clk), .rst_n(dst_rst_n), .d(launch_w[b]), .q(synced_w[b])
    );
  end

  gxc_gray_dec #(.WIDTH(WIDTH)) i_dec (
    .clk(dst_clk), .rst_n(dst_rst_n), .gray_i(synced_w), .bin_o(dst_count)
  );

  initial begin
    a_r6_stage_floor: assert (SYNC_STAGES >= GXC_MIN_STAGES && WIDTH >= GXC_MIN_WIDTH);
  end

  // R5: the launch word is flop-driven: mid-cycle snapshot equals value at next rise
  logic [WIDTH-1:0] launch_mid_q;
  always_ff @(negedge src_clk or negedge src_rst_n) begin
    if (!src_rst_n) launch_mid_q <= '0;
    else            launch_mid_q <= launch_w;
  end

  a_r5_launch_from_flop: assert property (@(posedge src_clk) disable iff (!src_rst_n)
    launch_w == launch_mid_q);
endmodule

// File: tb/test_gray_count_xing.sv
`timescale 1ns/1ps
module test_gray_count_xing;
  localparam int W = 6;
  localparam int BOUND = 12;

  logic src_clk = 0, dst_clk = 0;
  logic src_rst_n = 0, dst_rst_n = 0, src_step = 0;
  logic [W-1:0] src_count, src_gray, dst_count;
  real dst_half = 8.5;
  int checks = 0, failures = 0;
  bit mon_src = 0, mon_dst = 0, done = 0;
  logic [W-1:0] model = '0, prev_gray = '0, prev_dst = '0;

  always #5 src_clk = ~src_clk;
  always #(dst_half) dst_clk = ~dst_clk;

  gray_count_xing #(.WIDTH(W), .SYNC_STAGES(2)) i_gray_count_xing (
    .src_clk(src_clk), .src_rst_n(src_rst_n), .src_step(src_step),
    .src_count(src_count), .src_gray(src_gray),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .dst_count(dst_count)
  );

  function automatic logic [W-1:0] to_gray(logic [W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // source-side model: R2, R3, R4
  always @(negedge src_clk) if (mon_src) begin
    model = model + W'(src_step);
    check(src_count == model, "R3 count", src_count, model);
    check(src_gray == to_gray(model), "R2 gray", src_gray, to_gray(model));
    check($countones(src_gray ^ prev_gray) <= 1, "R4 one-bit", src_gray, prev_gray);
    prev_gray = src_gray;
  end

  // destination-side: R7 forward only, R8 recently held
  always @(negedge dst_clk) if (mon_dst) begin
    logic [W-1:0] fwd, lag;
    fwd = dst_count - prev_dst;
    lag = src_count - dst_count;
    check(int'(fwd) <= BOUND, "R7 forward", dst_count, prev_dst);
    check(int'(lag) <= BOUND, "R8 held", dst_count, src_count);
    prev_dst = dst_count;
  end

  task automatic run(int n, int dens);
    repeat (n) begin
      @(negedge src_clk); #1;
      src_step = (($urandom % 100) < dens);
    end
    @(negedge src_clk); #1 src_step = 0;
  endtask

  task automatic settle();
    @(negedge src_clk); #1 src_step = 0;
    repeat (8) @(negedge dst_clk);
    check(dst_count == src_count, "R6 settle", dst_count, src_count);
  endtask

  task automatic go_to(logic [W-1:0] v);
    logic [W-1:0] n;
    n = v - model;
    repeat (int'(n)) begin @(negedge src_clk); #1 src_step = 1; end
    @(negedge src_clk); #1 src_step = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #23;
    check(src_count == 0, "R1 src_count", src_count, 0);
    check(src_gray == 0, "R1 src_gray", src_gray, 0);
    check(dst_count == 0, "R1 dst_count", dst_count, 0);
    src_rst_n = 1; dst_rst_n = 1;
    repeat (2) @(negedge src_clk);
    mon_src = 1; mon_dst = 1;

    run(5, 100); settle();
    go_to(W'(63)); settle();
    check(dst_count == 63, "R6 max", dst_count, 63);
    go_to(W'(0)); settle();
    check(dst_count == 0, "R3 wrap", dst_count, 0);
    run(300, 50);  settle();
    run(400, 100); settle();
    run(300, 20);  settle();

    dst_half = 3.7;
    repeat (4) @(negedge dst_clk);
    run(400, 100); settle();
    go_to(W'(63)); settle();
    go_to(W'(0)); settle();
    check(dst_count == 0, "R3 wrap fast", dst_count, 0);
    run(300, 70); settle();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule